// File: doc/BRIEF.md
# Peripheral I/O Port Register Decoder

This block is the register file and read decoder behind a small peripheral I/O window. A 4-bit offset selects one of sixteen byte locations. They hold a version/region byte, three controller port data locations, three port control registers, three serial transmit-data registers and three serial-control registers. Three locations in the window are holes.

A read strobe samples the offset and returns the selected byte one clock later. A data-port read is assembled at read time. Its low seven bits come from that port's live pin levels, and its top bit comes from bit 7 of the same port's control register. The version byte is built from strap inputs at read time.

Writes update the control, transmit-data and serial-control registers. Writes to any other offset are dropped. Serial shifting and the controller protocol are outside this block.

Top module: `io_space_decoder`

## Requirements
- R1: After reset, rdata_o and unmapped_o are 0 and every control, transmit-data and serial-control register reads back 0x00.
- R2: Offset 0x0 returns {overseas_i, pal_i, ~exp_present_i, 1'b0, HW_REV[3:0]}, taking the strap levels present in the cycle of the read strobe. With the default HW_REV = 0, bits 4:0 are zero.
- R3: Offsets 0x1, 0x2 and 0x3 return the data of ports A, B and C. Bits 6:0 are that port's pin levels (pins_i[6:0] for port A, [13:7] for B, [20:14] for C) sampled in the read cycle, and bit 7 is bit 7 of that port's control register.
- R4: Offsets 0x4, 0x5 and 0x6 hold the control registers of ports A, B and C and return them unchanged.
- R5: Offsets 0x7, 0xA and 0xD hold the transmit-data registers of ports A, B and C (base 7, stride 3) and return them unchanged.
- R6: Offsets 0x9, 0xC and 0xF hold the serial-control registers of ports A, B and C (base 9, stride 3) and return them unchanged.
- R7: A read of offset 0x8, 0xB or 0xE returns 0x00 and raises unmapped_o for exactly the one cycle in which that read data is presented.
- R8: Read data appears on rdata_o on the clock edge after rd_i is sampled high. In a cycle that follows no read, rdata_o keeps its value and unmapped_o is 0.
- R9: A write to offset 0x0, 0x1, 0x2, 0x3, 0x8, 0xB or 0xE changes no register.
- R10: When a read and a write address the same register in one cycle, the read returns the value held before the write, and the new value is seen by a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Byte offset within the I/O window |
| wdata_i | input | 8 | Write data |
| overseas_i | input | 1 | Region strap, 1 = overseas |
| pal_i | input | 1 | Video standard strap, 1 = 50 Hz |
| exp_present_i | input | 1 | Expansion unit attached |
| pins_i | input | 21 | Port pin levels, 7 bits per port, port A lowest |
| rdata_o | output | 8 | Registered read data |
| unmapped_o | output | 1 | One-cycle flag for a read of a hole |

## Verification
Directed patterns come first. Control values with bit 7 set and with bit 7 clear are written and then read back through the data ports, which shows whether the top bit comes from the control register or from the pins. Distinct values are written to each serial register, which exposes a wrong stride or base. Writes are aimed at the read-only offsets and the holes to catch stray write enables. A read and a write to the same register in one cycle shows whether read data is taken before the write lands. A long random run then varies the pins, straps, offsets and strobe overlap on every cycle, so latency, hold and strap packing are compared against the model on each clock.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int BYTE_W     = 8;
  localparam int DATA_BASE  = 1;
  localparam int CTRL_BASE  = 4;
  localparam int TX_BASE    = 7;
  localparam int SCTL_BASE  = 9;
  localparam int SER_STRIDE = 3;

  typedef enum logic [2:0] {
    SEL_VER,
    SEL_DATA,
    SEL_CTRL,
    SEL_TX,
    SEL_SCTL,
    SEL_NONE
  } sel_kind_e;
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_dec_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 4,
  parameter int PIDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_kind_e         kind_o,
  output logic [PIDX_W-1:0] port_o
);
  always_comb begin
    kind_o = SEL_NONE;
    port_o = '0;
    if (addr_i == '0) kind_o = SEL_VER;
    for (int p = 0; p < N_PORTS; p++) begin
      if (int'(addr_i) == DATA_BASE + p) begin
        kind_o = SEL_DATA;
        port_o = PIDX_W'(p);
      end
      if (int'(addr_i) == CTRL_BASE + p) begin
        kind_o = SEL_CTRL;
        port_o = PIDX_W'(p);
      end
      if (int'(addr_i) == TX_BASE + SER_STRIDE * p) begin
        kind_o = SEL_TX;
        port_o = PIDX_W'(p);
      end
      if (int'(addr_i) == SCTL_BASE + SER_STRIDE * p) begin
        kind_o = SEL_SCTL;
        port_o = PIDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/io_port_regs.sv
module io_port_regs
  import io_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              we_ctrl_i,
  input  logic              we_tx_i,
  input  logic              we_sctl_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] tx_o,
  output logic [BYTE_W-1:0] sctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= '0;
    else if (we_ctrl_i) ctrl_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_o <= '0;
    else if (we_tx_i) tx_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sctl_o <= '0;
    else if (we_sctl_i) sctl_o <= wdata_i;
  end
endmodule

// File: rtl/io_read_path.sv
module io_read_path
  import io_dec_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int PIN_W   = 7,
  parameter int PIDX_W  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  sel_kind_e                kind_i,
  input  logic [PIDX_W-1:0]        port_i,
  input  logic [BYTE_W-1:0]        version_i,
  input  logic [BYTE_W-1:0]        ctrl_i [N_PORTS],
  input  logic [BYTE_W-1:0]        tx_i   [N_PORTS],
  input  logic [BYTE_W-1:0]        sctl_i [N_PORTS],
  input  logic [N_PORTS*PIN_W-1:0] pins_i,
  output logic [BYTE_W-1:0]        rdata_o,
  output logic                     unmapped_o
);
  logic [BYTE_W-1:0] ctrl_sel, tx_sel, sctl_sel, rd_next;
  logic [PIN_W-1:0]  pins_sel;

  always_comb begin
    ctrl_sel = '0;
    tx_sel   = '0;
    sctl_sel = '0;
    pins_sel = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (port_i == PIDX_W'(p)) begin
        ctrl_sel = ctrl_i[p];
        tx_sel   = tx_i[p];
        sctl_sel = sctl_i[p];
        pins_sel = pins_i[p*PIN_W +: PIN_W];
      end
    end
  end

  always_comb begin
    unique case (kind_i)
      SEL_VER:  rd_next = version_i;
      SEL_DATA: rd_next = {ctrl_sel[BYTE_W-1], pins_sel};
      SEL_CTRL: rd_next = ctrl_sel;
      SEL_TX:   rd_next = tx_sel;
      SEL_SCTL: rd_next = sctl_sel;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      unmapped_o <= 1'b0;
    end else begin
      unmapped_o <= rd_i && (kind_i == SEL_NONE);
      if (rd_i) rdata_o <= rd_next;
    end
  end
endmodule

// File: rtl/io_space_decoder.sv
module io_space_decoder
  import io_dec_pkg::*;
#(
  parameter int          N_PORTS = 3,
  parameter int          ADDR_W  = 4,
  parameter logic [3:0]  HW_REV  = 4'h0,
  localparam int         PIN_W   = BYTE_W - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  input  logic                     overseas_i,
  input  logic                     pal_i,
  input  logic                     exp_present_i,
  input  logic [N_PORTS*PIN_W-1:0] pins_i,
  output logic [BYTE_W-1:0]        rdata_o,
  output logic                     unmapped_o
);
  localparam int PIDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  sel_kind_e         kind;
  logic [PIDX_W-1:0] port;
  logic [BYTE_W-1:0] ctrl_q [N_PORTS];
  logic [BYTE_W-1:0] tx_q   [N_PORTS];
  logic [BYTE_W-1:0] sctl_q [N_PORTS];
  logic [BYTE_W-1:0] version;

  assign version = {overseas_i, pal_i, ~exp_present_i, 1'b0, HW_REV};

  io_addr_decode #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .PIDX_W(PIDX_W)
  ) u_dec (
    .addr_i(addr_i), .kind_o(kind), .port_o(port)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_i && (port == PIDX_W'(p));
    io_port_regs u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wdata_i   (wdata_i),
      .we_ctrl_i (hit && (kind == SEL_CTRL)),
      .we_tx_i   (hit && (kind == SEL_TX)),
      .we_sctl_i (hit && (kind == SEL_SCTL)),
      .ctrl_o    (ctrl_q[p]),
      .tx_o      (tx_q[p]),
      .sctl_o    (sctl_q[p])
    );
  end

  io_read_path #(
    .N_PORTS(N_PORTS), .PIN_W(PIN_W), .PIDX_W(PIDX_W)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .kind_i     (kind),
    .port_i     (port),
    .version_i  (version),
    .ctrl_i     (ctrl_q),
    .tx_i       (tx_q),
    .sctl_i     (sctl_q),
    .pins_i     (pins_i),
    .rdata_o    (rdata_o),
    .unmapped_o (unmapped_o)
  );
endmodule

// File: rtl/io_space_decoder_chk.sv
module io_space_decoder_chk #(
  parameter int         N_PORTS = 3,
  parameter int         ADDR_W  = 4,
  parameter logic [3:0] HW_REV  = 4'h0,
  parameter int         PIN_W   = 7
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     rd_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic                     overseas_i,
  input logic                     pal_i,
  input logic                     exp_present_i,
  input logic [N_PORTS*PIN_W-1:0] pins_i,
  input logic [7:0]               rdata_o,
  input logic                     unmapped_o
);
  logic [PIN_W-1:0] pin_pick;
  logic             data_hit;

  always_comb begin
    pin_pick = '0;
    data_hit = 1'b0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (int'(addr_i) == 1 + p) begin
        pin_pick = pins_i[p*PIN_W +: PIN_W];
        data_hit = 1'b1;
      end
    end
  end

  a_r7_flag_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> $past(rd_i));

  a_r7_hole_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> (rdata_o == 8'h00));

  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ($stable(rdata_o) && !unmapped_o));

  a_r2_version_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == '0) |=>
      (rdata_o == {$past(overseas_i), $past(pal_i), !$past(exp_present_i), 1'b0, HW_REV}));

  a_r3_pin_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && data_hit) |=> (rdata_o[PIN_W-1:0] == $past(pin_pick)));
endmodule

bind io_space_decoder io_space_decoder_chk #(
  .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .HW_REV(HW_REV), .PIN_W(PIN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i),
  .overseas_i(overseas_i), .pal_i(pal_i), .exp_present_i(exp_present_i),
  .pins_i(pins_i), .rdata_o(rdata_o), .unmapped_o(unmapped_o)
);

// File: tb/sim_io_space_decoder.sv
module sim_io_space_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ovs = 1'b0, pal = 1'b0, expu = 1'b0;
  logic [20:0] pins = '0;
  logic [7:0]  rdata;
  logic        unm;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_space_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .overseas_i(ovs), .pal_i(pal), .exp_present_i(expu),
    .pins_i(pins), .rdata_o(rdata), .unmapped_o(unm)
  );

  int         checks = 0, failures = 0;
  logic [7:0] m_ctrl[3], m_tx[3], m_sctl[3];
  logic [7:0] exp_rd = '0;
  logic       exp_unm = 1'b0;
  string      exp_tag = "R1";

  task automatic compare();
    checks++;
    if (rdata !== exp_rd || unm !== exp_unm) begin
      failures++;
      $display("FAIL %s rdata=%h unmapped=%b expected rdata=%h unmapped=%b",
               exp_tag, rdata, unm, exp_rd, exp_unm);
    end
  endtask

  // one cycle: check previous expectation, drive, predict
  task automatic step(input bit r, input bit w, input logic [3:0] a,
                      input logic [7:0] d, input string tag = "");
    int ia;
    @(negedge clk);
    compare();
    rd = r; wr = w; addr = a; wdata = d;
    pins = 21'($urandom); ovs = 1'($urandom); pal = 1'($urandom); expu = 1'($urandom);
    ia = int'(a);
    if (r) begin
      exp_unm = 1'b0;
      if (ia == 0) begin
        exp_rd = {ovs, pal, ~expu, 5'b0}; exp_tag = "R2";
      end else if (ia <= 3) begin
        exp_rd = {m_ctrl[ia-1][7], pins[(ia-1)*7 +: 7]}; exp_tag = "R3";
      end else if (ia <= 6) begin
        exp_rd = m_ctrl[ia-4]; exp_tag = "R4";
      end else if ((ia - 7) % 3 == 0) begin
        exp_rd = m_tx[(ia-7)/3]; exp_tag = "R5";
      end else if ((ia - 9) % 3 == 0) begin
        exp_rd = m_sctl[(ia-9)/3]; exp_tag = "R6";
      end else begin
        exp_rd = 8'h00; exp_unm = 1'b1; exp_tag = "R7";
      end
    end else begin
      exp_unm = 1'b0; exp_tag = "R8";
    end
    if (tag != "") exp_tag = tag;
    if (w) begin
      if (ia >= 4 && ia <= 6) m_ctrl[ia-4] = d;
      else if (ia >= 7 && (ia - 7) % 3 == 0) m_tx[(ia-7)/3] = d;
      else if (ia >= 9 && (ia - 9) % 3 == 0) m_sctl[(ia-9)/3] = d;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_ctrl[i] = '0; m_tx[i] = '0; m_sctl[i] = '0; end
    repeat (3) @(negedge clk);
    compare();                             // R1 reset state
    @(negedge clk); rst_n = 1'b1;
    for (int a = 4; a < 16; a++) step(1, 0, 4'(a), 8'h00, "R1");
    for (int a = 0; a < 4; a++) step(1, 0, 4'(a), 8'h00);
    // R3: top bit from control, pins below
    step(0, 1, 4'h4, 8'h80); step(0, 1, 4'h5, 8'h7F); step(0, 1, 4'h6, 8'hFF);
    for (int k = 0; k < 4; k++)
      for (int a = 1; a < 7; a++) step(1, 0, 4'(a), 8'h00);
    // R5 / R6 distinct values per serial register
    step(0, 1, 4'h7, 8'h11); step(0, 1, 4'hA, 8'h22); step(0, 1, 4'hD, 8'h33);
    step(0, 1, 4'h9, 8'h44); step(0, 1, 4'hC, 8'h55); step(0, 1, 4'hF, 8'h66);
    for (int a = 7; a < 16; a++) step(1, 0, 4'(a), 8'h00);
    // R9 writes to read-only offsets and holes
    step(0, 1, 4'h0, 8'hAA); step(0, 1, 4'h1, 8'hAA); step(0, 1, 4'h2, 8'hAA);
    step(0, 1, 4'h3, 8'hAA); step(0, 1, 4'h8, 8'hAA); step(0, 1, 4'hB, 8'hAA);
    step(0, 1, 4'hE, 8'hAA);
    for (int a = 0; a < 16; a++) step(1, 0, 4'(a), 8'h00, "R9");
    // R10 read and write same register in one cycle
    step(1, 1, 4'h4, 8'h3C, "R10");
    step(1, 1, 4'hA, 8'hC3, "R10");
    step(1, 1, 4'hF, 8'h5A, "R10");
    step(1, 0, 4'h4, 8'h00); step(1, 0, 4'hA, 8'h00); step(1, 0, 4'hF, 8'h00);
    // R8 hold across idle cycles, R7 flag drops after one cycle
    step(1, 0, 4'h5, 8'h00);
    step(0, 0, 4'h0, 8'h00); step(0, 0, 4'h3, 8'h00);
    step(1, 0, 4'hB, 8'h00); step(0, 0, 4'h0, 8'h00); step(0, 0, 4'h8, 8'h00);
    // random mix
    for (int n = 0; n < 3000; n++)
      step(1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom));
    step(0, 0, 4'h0, 8'h00);
    @(negedge clk); compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule